// File: doc/BRIEF.md
# Base Address Window Register and Decoder

This block holds one 32-bit base address register for a bus target and decodes incoming transaction addresses against it. Configuration software first discovers the window the device needs: it saves the register, writes all ones, reads the result back, clears the low four bits and takes the two's complement to get the window size in bytes. It then writes the base address it has chosen. Once the command register's decode-enable bit is set, the device claims every address inside that naturally aligned window.

The window size is a power of two, at least 16 bytes, and is fixed by a parameter. Register bits between bit 4 and the window size boundary are hard-wired to zero, so they read back as zero after an all-ones write and turn that readback into a size mask. The lowest four bits are not storage. They are constant type flags chosen by parameters: I/O versus memory space, the memory locatable type, and prefetchability.

Top module: `bar_window_decoder`

## Requirements
- R1: After reset every writable base bit is zero, so a read returns only the type flags. The bench uses the default configuration (memory space, 32-bit locatable, prefetchable, 4 KiB window), which reads back as 0x00000008.
- R2: Bits 3:0 are read-only and ignore writes. For a memory window, bit 0 is 0, bits 2:1 give the locatable type (00 for 32-bit, 10 for 64-bit) and bit 3 is the prefetchable flag. For an I/O window, bit 0 is 1 and bits 3:1 are 0.
- R3: After an all-ones write, a read returns ones in bits 31:log2(size) and zeros in bits log2(size)-1:4. Clearing bits 3:0 of that value and taking its two's complement gives the window size in bytes.
- R4: Bits 31:log2(size) store any written value and return it unchanged on a later read, so software can save the register and restore it.
- R5: A configuration write takes effect at the next rising clock edge. A read in the same cycle as the write returns the old value.
- R6: When decode is enabled, hit is high exactly when bits 31:log2(size) of the transaction address equal the programmed base. Hit is combinational from the address.
- R7: When decode-enable is low, hit stays low for every address.
- R8: With no write, the read data holds its value from cycle to cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Full-word configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Current register value: base bits, zero bits and type flags |
| decode_en | input | 1 | Decode enable, models the command register bit |
| txn_addr | input | 32 | Transaction address to decode |
| hit | output | 1 | Address falls inside the enabled window |

## Verification
The assertions assume that the write strobe and write data are stable around the rising edge, and that they carry known values once reset is released. The hit checks also assume that the transaction address is known whenever decode-enable is high. The bench drives every input at the falling edge with fully defined values and holds reset for several cycles before the first access. It keeps decode-enable low while the base still holds the all-ones sizing pattern or the save/restore values, and sets it only after a real base has been written.

// File: rtl/bar_pkg.sv
package bar_pkg;
   localparam int unsigned REG_W     = 32;
   localparam int unsigned FLAG_W    = 4;
   localparam logic [1:0]  LOC_32BIT = 2'b00;
   localparam logic [1:0]  LOC_64BIT = 2'b10;

   // Compose the constant low nibble from the window kind.
   function automatic logic [FLAG_W-1:0] flag_nibble(input bit io_space,
                                                     input logic [1:0] loc,
                                                     input bit prefetch);
      if (io_space)
         return 4'b0001;
      else
         return {prefetch, loc, 1'b0};
   endfunction
endpackage

// File: rtl/bar_type_flags.sv
module bar_type_flags
   import bar_pkg::*;
#(
   parameter bit         IO_SPACE = 1'b0,
   parameter logic [1:0] LOC_TYPE = LOC_32BIT,
   parameter bit         PREFETCH = 1'b1
) (
   output logic [FLAG_W-1:0] flags
);
   generate
      if (IO_SPACE) begin : g_io
         assign flags = flag_nibble(1'b1, 2'b00, 1'b0);
      end else begin : g_mem
         assign flags = flag_nibble(1'b0, LOC_TYPE, PREFETCH);
      end
   endgenerate
endmodule

// File: rtl/bar_base_reg.sv
module bar_base_reg
   import bar_pkg::*;
#(
   parameter int unsigned WIN_LOG2 = 12,
   localparam int unsigned BASE_W  = REG_W - WIN_LOG2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [REG_W-1:0]  wdata,
   output logic [BASE_W-1:0] base
);
   logic [BASE_W-1:0] base_q;

   // Only bits at or above the window boundary are stored.
   always_ff @(posedge clk) begin
      if (!rst_n)
         base_q <= '0;
      else if (wr)
         base_q <= wdata[REG_W-1:WIN_LOG2];
   end

   assign base = base_q;
endmodule

// File: rtl/bar_addr_match.sv
module bar_addr_match
   import bar_pkg::*;
#(
   parameter int unsigned WIN_LOG2 = 12,
   localparam int unsigned BASE_W  = REG_W - WIN_LOG2
) (
   input  logic              enable,
   input  logic [BASE_W-1:0] base,
   input  logic [REG_W-1:0]  addr,
   output logic              match
);
   logic same_window;

   assign same_window = (addr[REG_W-1:WIN_LOG2] == base);
   assign match       = enable && same_window;
endmodule

// File: rtl/bar_window_decoder.sv
module bar_window_decoder
   import bar_pkg::*;
#(
   parameter int unsigned WIN_LOG2 = 12,
   parameter bit          IO_SPACE = 1'b0,
   parameter logic [1:0]  LOC_TYPE = 2'b00,
   parameter bit          PREFETCH = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_wr,
   input  logic [31:0] cfg_wdata,
   output logic [31:0] cfg_rdata,
   input  logic        decode_en,
   input  logic [31:0] txn_addr,
   output logic        hit
);
   localparam int unsigned  BASE_W  = REG_W - WIN_LOG2;
   localparam int unsigned  GAP_W   = WIN_LOG2 - FLAG_W;
   localparam logic [31:0]  LOW_MSK = (32'h1 << WIN_LOG2) - 32'h1;

   initial begin
      if (WIN_LOG2 < 4 || WIN_LOG2 > 31)
         $error("WIN_LOG2 must lie in 4..31");
      if (!IO_SPACE && LOC_TYPE != LOC_32BIT && LOC_TYPE != LOC_64BIT)
         $error("LOC_TYPE must be 2'b00 or 2'b10");
      if (IO_SPACE && PREFETCH)
         $error("an I/O window cannot be prefetchable");
   end

   logic [FLAG_W-1:0] flags;
   logic [BASE_W-1:0] base;

   bar_type_flags #(
      .IO_SPACE (IO_SPACE),
      .LOC_TYPE (LOC_TYPE),
      .PREFETCH (PREFETCH)
   ) u_flags (
      .flags (flags)
   );

   bar_base_reg #(
      .WIN_LOG2 (WIN_LOG2)
   ) u_base (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (cfg_wr),
      .wdata (cfg_wdata),
      .base  (base)
   );

   bar_addr_match #(
      .WIN_LOG2 (WIN_LOG2)
   ) u_match (
      .enable (decode_en),
      .base   (base),
      .addr   (txn_addr),
      .match  (hit)
   );

   // Read view: stored base, hard zeros below the window boundary, flags.
   generate
      if (GAP_W > 0) begin : g_gap
         assign cfg_rdata = {base, {GAP_W{1'b0}}, flags};
      end else begin : g_nogap
         assign cfg_rdata = {base, flags};
      end
   endgenerate

   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> cfg_rdata[31:WIN_LOG2] == $past(cfg_wdata[31:WIN_LOG2])); // R5
   AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_wr |=> $stable(cfg_rdata)); // R8
   AST_FLAGS_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> $stable(cfg_rdata[3:0])); // R2
   AST_DECODE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !decode_en |-> !hit); // R7
   AST_HIT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (((txn_addr ^ cfg_rdata) & ~LOW_MSK) == 32'h0)); // R6
endmodule

// File: tb/bar_window_decoder_test.sv
module bar_window_decoder_test;
   localparam int unsigned WL       = 12;
   localparam logic [31:0] EXP_FLAG = 32'h0000_0008;
   localparam logic [31:0] UP_MSK   = ~((32'h1 << WL) - 32'h1);

   typedef struct {
      logic [31:0] rdata;
      logic        hit;
      string       req;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        decode_en = 1'b0;
   logic [31:0] txn_addr = '0;
   logic        hit;

   int   errors = 0;
   int   checks = 0;
   bit   done = 0;
   exp_t sb[$];
   event smp;

   always #5 clk = ~clk;

   bar_window_decoder uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_wr    (cfg_wr),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .decode_en (decode_en),
      .txn_addr  (txn_addr),
      .hit       (hit)
   );

   // Monitor: pop the next expectation and compare it with the outputs.
   always @(smp) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (cfg_rdata !== e.rdata || hit !== e.hit) begin
         errors++;
         $display("FAIL %s: rdata=%h hit=%b expected rdata=%h hit=%b",
                  e.req, cfg_rdata, hit, e.rdata, e.hit);
      end
   end

   task automatic expect_now(input logic [31:0] rd, input logic h, input string req);
      exp_t e;
      e.rdata = rd; e.hit = h; e.req = req;
      sb.push_back(e);
      #1 ->smp;
      #1;
   endtask

   task automatic probe(input logic en, input logic [31:0] a,
                        input logic [31:0] rd, input logic h, input string req);
      @(negedge clk);
      decode_en = en;
      txn_addr  = a;
      expect_now(rd, h, req);
   endtask

   // Write, and check in the same cycle that the old value is still read.
   task automatic cfg_write(input logic [31:0] d, input logic [31:0] old, input string req);
      @(negedge clk);
      decode_en = 1'b0;
      cfg_wr    = 1'b1;
      cfg_wdata = d;
      expect_now(old, 1'b0, req);
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   initial begin
      logic [31:0] size;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      probe(1'b0, 32'h0, EXP_FLAG, 1'b0, "R1 reset value");
      probe(1'b0, 32'h0, EXP_FLAG, 1'b0, "R7 decode off after reset");

      // Sizing sequence.
      cfg_write(32'hFFFF_FFFF, EXP_FLAG, "R5 old value during write");
      probe(1'b0, 32'h0, UP_MSK | EXP_FLAG, 1'b0, "R3 all-ones readback");
      size = ~(cfg_rdata & 32'hFFFF_FFF0) + 32'h1;
      checks++;
      if (size !== (32'h1 << WL)) begin
         errors++;
         $display("FAIL R3 size: got %0d expected %0d", size, 32'h1 << WL);
      end

      // Save/restore of arbitrary values; low nibble ignores writes.
      cfg_write(32'h1234_5678, UP_MSK | EXP_FLAG, "R5 old value during write");
      probe(1'b0, 32'h0, 32'h1234_5008, 1'b0, "R4 R2 arbitrary readback");
      cfg_write(32'hABCD_E000, 32'h1234_5008, "R5 old value during write");
      probe(1'b0, 32'h0, 32'hABCD_E008, 1'b0, "R4 restore readback");
      cfg_write(32'h0000_0007, 32'hABCD_E008, "R5 old value during write");
      probe(1'b0, 32'h0, EXP_FLAG, 1'b0, "R2 flags ignore writes");

      // Real base assignment and decoding.
      cfg_write(32'h8000_0000, EXP_FLAG, "R5 old value during write");
      probe(1'b0, 32'h8000_0010, 32'h8000_0008, 1'b0, "R7 decode disabled");
      probe(1'b1, 32'h8000_0000, 32'h8000_0008, 1'b1, "R6 window start");
      probe(1'b1, 32'h8000_0FFC, 32'h8000_0008, 1'b1, "R6 window end");
      probe(1'b1, 32'h8000_1000, 32'h8000_0008, 1'b0, "R6 just above window");
      probe(1'b1, 32'h7FFF_FFFC, 32'h8000_0008, 1'b0, "R6 just below window");
      probe(1'b1, 32'h0000_0000, 32'h8000_0008, 1'b0, "R6 far address");
      probe(1'b1, 32'h8000_0800, 32'h8000_0008, 1'b1, "R8 stable without write");
      probe(1'b0, 32'h8000_0800, 32'h8000_0008, 1'b0, "R7 decode dropped");

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule